// File: doc/BRIEF.md
# Command Queue Thread Sequencer

This block is a single execution thread of a command-queue engine. Software sets it up through a small register window with a start address, an end bound, an interrupt enable mask and an enable bit. Once enabled, the thread fetches 64-bit instructions from memory one at a time. Each fetch is a held request that completes on an acknowledge. The thread executes jumps (absolute or relative), waits on event lines, and treats every other instruction as a no-op. It stops and signals done when its program counter reaches the end bound.

The thread can be changed while it runs. Software can pause it at an instruction boundary, rewrite the program counter and end bound, and let it go again. Any write to the program counter throws away an instruction that is still in flight or is parked in a wait, and fetching starts again from the written value. An absolute-jump instruction placed at the tail of a running buffer lets software chain a newly queued buffer onto it. A warm-reset handshake returns the control registers to zero without touching the rest of the chip.

Program counter and end bound hold the byte address shifted right by the parameter `SHIFT` (0 or 3). Instructions are 8 bytes long.

Top module: `cq_thread_seq`

## Requirements
- R1: After reset, every register in the window reads zero, except status offset 0x0C, whose bit 1 reads 1 because the thread is disabled. The offsets are: 0x00 warm reset, 0x04 enable (bit 0), 0x08 pause (bit 0), 0x0C status, 0x10 interrupt status, 0x14 interrupt enable, 0x20 program counter, 0x24 end bound, 0x30 wait flag, 0x40 priority.
- R2: Writing 1 to bit 0 of offset 0x00 starts a warm reset. That bit then reads 1 for `RST_CYCLES` cycles and then clears by itself. The reset sets enable, pause, priority, interrupt enable, program counter and end bound to zero. Writes to other registers are ignored while the reset is in progress.
- R3: When enabled and not paused, the thread issues a fetch at byte address PC<<SHIFT. It holds `mem_req` and `mem_addr` steady until `mem_ack`. After a non-jump instruction the PC advances by 8>>SHIFT.
- R4: When the PC equals the end bound, no further fetch is issued and interrupt status bit 0 (done) is set. The thread stays enabled, and moving the end bound past the PC makes it continue.
- R5: An instruction whose upper word is 0x10000001 loads the PC with its lower word >> SHIFT. An upper word of 0x10000000 adds the lower word, taken as a signed byte offset and arithmetically shifted right by SHIFT, to the PC.
- R6: An upper word of 0x20000000 is a wait on event line (lower word). While the thread waits, the PC stays on that instruction and bit 31 of offset 0x30 reads 1. When the line is high the PC advances. An event number of `EVT_N` or above sets interrupt status bit 4 and stops the thread.
- R7: Writing 1 to offset 0x08 lets an outstanding fetch finish and then starts no new one. Status bit 1 at 0x0C reads 1 once the thread has stopped, and always while it is disabled. Writing 0 resumes the thread.
- R8: Any write to offset 0x20, including its current value, discards the instruction in flight or in a wait. The next fetch uses the written address.
- R9: A fetch whose byte address lies outside [`LEGAL_LO`, `LEGAL_HI`) is not issued. Interrupt status bit 1 is set instead, and the thread stays stopped until it is disabled.
- R10: Interrupt status bits 0, 1 and 4 are cleared by writing 0 to them; writing 1 leaves them unchanged. `irq` is high exactly when some status bit is set whose enable bit at 0x14 is also set.
- R11: Offset 0x40 stores and reads back a `PRIO_W`-bit priority value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Instruction fetch request, held until acknowledged |
| mem_addr | output | 32 | Fetch byte address |
| mem_ack | input | 1 | Fetch completion, one cycle |
| mem_rdata | input | 64 | Fetched instruction, valid with `mem_ack` |
| evt_in | input | EVT_N | Event lines tested by wait instructions |
| irq | output | 1 | Done/error interrupt |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high, and for a single cycle per fetch. The bench responder follows this rule. It answers each held request after a random or fixed delay and drops the acknowledge on the following cycle. The assertions also assume that software does not move the PC outside the legal range during a fetch. The random programs therefore only jump forward inside a buffer that ends in the legal window. Event lines change only while the bench has a wait test running.

// File: rtl/cqt_pkg.sv
package cqt_pkg;
  localparam logic [31:0] OP_JUMP_ABS = 32'h1000_0001;
  localparam logic [31:0] OP_JUMP_REL = 32'h1000_0000;
  localparam logic [31:0] OP_WAIT_EVT = 32'h2000_0000;

  localparam logic [7:0] OFS_WRST  = 8'h00;
  localparam logic [7:0] OFS_EN    = 8'h04;
  localparam logic [7:0] OFS_PAUSE = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [7:0] OFS_ISTS  = 8'h10;
  localparam logic [7:0] OFS_IEN   = 8'h14;
  localparam logic [7:0] OFS_PC    = 8'h20;
  localparam logic [7:0] OFS_END   = 8'h24;
  localparam logic [7:0] OFS_WAIT  = 8'h30;
  localparam logic [7:0] OFS_PRIO  = 8'h40;

  localparam int IRQ_W = 5;
  localparam logic [IRQ_W-1:0] IRQ_MASK = 5'b1_0011;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_FETCH, ST_WAIT, ST_DONE, ST_ERR
  } seq_state_t;

  typedef enum logic [1:0] {K_STEP, K_JUMP, K_WAIT} ikind_t;
endpackage

// File: rtl/cqt_decode.sv
module cqt_decode
  import cqt_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int EVT_N = 8,
  localparam int EVT_W = (EVT_N > 1) ? $clog2(EVT_N) : 1
) (
  input  logic [63:0]      instr,
  input  logic [31:0]      pc,
  output ikind_t           kind,
  output logic [31:0]      next_pc,
  output logic [EVT_W-1:0] evt_idx,
  output logic             evt_bad
);
  localparam logic [31:0] INC = 32'd8 >> SHIFT;

  logic [31:0] hi, lo;
  assign hi = instr[63:32];
  assign lo = instr[31:0];

  always_comb begin
    kind    = K_STEP;
    next_pc = pc + INC;
    evt_idx = lo[EVT_W-1:0];
    evt_bad = (lo >= 32'(EVT_N));
    if (hi == OP_JUMP_ABS) begin
      kind    = K_JUMP;
      next_pc = lo >> SHIFT;
    end else if (hi == OP_JUMP_REL) begin
      kind    = K_JUMP;
      next_pc = pc + $unsigned($signed(lo) >>> SHIFT);
    end else if (hi == OP_WAIT_EVT) begin
      kind    = K_WAIT;
    end
  end
endmodule

// File: rtl/cqt_warm_rst.sv
module cqt_warm_rst #(
  parameter int CYC = 4,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start) cnt_n = CW'(CYC);
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/cqt_irq.sv
module cqt_irq
  import cqt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr_wr,
  input  logic [IRQ_W-1:0] clr_data,
  input  logic [IRQ_W-1:0] set,
  input  logic [IRQ_W-1:0] ena,
  output logic [IRQ_W-1:0] sts,
  output logic             irq
);
  logic [IRQ_W-1:0] sts_n;

  always_comb begin
    sts_n = sts;
    if (clr_wr) sts_n = sts_n & clr_data;
    sts_n = (sts_n | set) & IRQ_MASK;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sts <= '0;
    else         sts <= sts_n;
  end

  assign irq = |(sts & ena);
endmodule

// File: rtl/cq_thread_seq.sv
module cq_thread_seq
  import cqt_pkg::*;
#(
  parameter int          SHIFT      = 0,
  parameter int          EVT_N      = 8,
  parameter int          PRIO_W     = 3,
  parameter int          RST_CYCLES = 4,
  parameter logic [31:0] LEGAL_LO   = 32'h0000_0000,
  parameter logic [31:0] LEGAL_HI   = 32'h8000_0000,
  localparam int         EVT_W      = (EVT_N > 1) ? $clog2(EVT_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata,
  input  logic [EVT_N-1:0] evt_in,
  output logic             irq
);
  localparam logic [31:0] INC = 32'd8 >> SHIFT;

  logic [1:0] rsync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_ni = rsync[1];

  seq_state_t       state_q, state_n;
  logic             en_q, en_n, susp_q, susp_n, flush_q, flush_n;
  logic [PRIO_W-1:0] prio_q, prio_n;
  logic [31:0]      pc_q, pc_n, end_q, end_n, faddr_q, faddr_n, fsm_pc;
  logic [IRQ_W-1:0] irqen_q, irqen_n, irq_set, irq_sts;
  logic [EVT_W-1:0] widx_q, widx_n;

  logic rst_busy, rst_go, wr_ok, pc_wr, bad_addr, stopped, waiting;
  logic [31:0] fetch_ba;
  ikind_t      dec_kind;
  logic [31:0] dec_next;
  logic [EVT_W-1:0] dec_idx;
  logic        dec_bad;

  assign wr_ok    = reg_wr && !rst_busy;
  assign rst_go   = wr_ok && (reg_addr == OFS_WRST) && reg_wdata[0];
  assign pc_wr    = wr_ok && (reg_addr == OFS_PC);
  assign fetch_ba = pc_q << SHIFT;
  assign bad_addr = (fetch_ba < LEGAL_LO) || (fetch_ba >= LEGAL_HI);

  cqt_warm_rst #(.CYC(RST_CYCLES)) u_wrst (
    .clk(clk), .rst_ni(rst_ni), .start(rst_go), .busy(rst_busy));

  cqt_decode #(.SHIFT(SHIFT), .EVT_N(EVT_N)) u_dec (
    .instr(mem_rdata), .pc(pc_q), .kind(dec_kind), .next_pc(dec_next),
    .evt_idx(dec_idx), .evt_bad(dec_bad));

  cqt_irq u_irq (
    .clk(clk), .rst_ni(rst_ni),
    .clr_wr(wr_ok && (reg_addr == OFS_ISTS)), .clr_data(reg_wdata[IRQ_W-1:0]),
    .set(irq_set), .ena(irqen_q), .sts(irq_sts), .irq(irq));

  // sequencer next state
  always_comb begin
    state_n = state_q;
    faddr_n = faddr_q;
    flush_n = flush_q;
    widx_n  = widx_q;
    fsm_pc  = pc_q;
    irq_set = '0;
    case (state_q)
      ST_IDLE: if (en_q) state_n = ST_RUN;
      ST_RUN: begin
        if (!en_q) state_n = ST_IDLE;
        else if (!susp_q) begin
          if (pc_q == end_q) begin
            state_n = ST_DONE;
            irq_set[0] = 1'b1;
          end else if (bad_addr) begin
            state_n = ST_ERR;
            irq_set[1] = 1'b1;
          end else begin
            state_n = ST_FETCH;
            faddr_n = fetch_ba;
            flush_n = pc_wr;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          flush_n = 1'b0;
          if (flush_q || pc_wr || !en_q) state_n = en_q ? ST_RUN : ST_IDLE;
          else if (dec_kind == K_WAIT) begin
            if (dec_bad) begin
              state_n = ST_ERR;
              irq_set[4] = 1'b1;
            end else begin
              widx_n  = dec_idx;
              state_n = ST_WAIT;
            end
          end else begin
            fsm_pc  = dec_next;
            state_n = ST_RUN;
          end
        end else if (pc_wr || !en_q) flush_n = 1'b1;
      end
      ST_WAIT: begin
        if (!en_q) state_n = ST_IDLE;
        else if (pc_wr) state_n = ST_RUN;
        else if (!susp_q && evt_in[widx_q]) begin
          fsm_pc  = pc_q + INC;
          state_n = ST_RUN;
        end
      end
      ST_DONE: begin
        if (!en_q) state_n = ST_IDLE;
        else if (pc_q != end_q) state_n = ST_RUN;
      end
      ST_ERR: if (!en_q) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // control registers next state
  always_comb begin
    en_n    = en_q;
    susp_n  = susp_q;
    prio_n  = prio_q;
    end_n   = end_q;
    irqen_n = irqen_q;
    pc_n    = fsm_pc;
    if (wr_ok) begin
      case (reg_addr)
        OFS_EN:    en_n    = reg_wdata[0];
        OFS_PAUSE: susp_n  = reg_wdata[0];
        OFS_IEN:   irqen_n = reg_wdata[IRQ_W-1:0] & IRQ_MASK;
        OFS_PC:    pc_n    = reg_wdata;
        OFS_END:   end_n   = reg_wdata;
        OFS_PRIO:  prio_n  = reg_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
    if (rst_go) begin
      en_n = 1'b0; susp_n = 1'b0; prio_n = '0;
      end_n = '0; irqen_n = '0; pc_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; en_q <= 1'b0; susp_q <= 1'b0; flush_q <= 1'b0;
      prio_q <= '0; pc_q <= '0; end_q <= '0; faddr_q <= '0;
      irqen_q <= '0; widx_q <= '0;
    end else begin
      state_q <= state_n; en_q <= en_n; susp_q <= susp_n; flush_q <= flush_n;
      prio_q <= prio_n; pc_q <= pc_n; end_q <= end_n; faddr_q <= faddr_n;
      irqen_q <= irqen_n; widx_q <= widx_n;
    end
  end

  assign mem_req  = (state_q == ST_FETCH);
  assign mem_addr = faddr_q;
  assign waiting  = (state_q == ST_WAIT);
  assign stopped  = !en_q || (susp_q && state_q != ST_FETCH);

  always_comb begin
    case (reg_addr)
      OFS_WRST:  reg_rdata = {31'd0, rst_busy};
      OFS_EN:    reg_rdata = {31'd0, en_q};
      OFS_PAUSE: reg_rdata = {31'd0, susp_q};
      OFS_STAT:  reg_rdata = {30'd0, stopped, 1'b0};
      OFS_ISTS:  reg_rdata = {{(32-IRQ_W){1'b0}}, irq_sts};
      OFS_IEN:   reg_rdata = {{(32-IRQ_W){1'b0}}, irqen_q};
      OFS_PC:    reg_rdata = pc_q;
      OFS_END:   reg_rdata = end_q;
      OFS_WAIT:  reg_rdata = {waiting, 31'd0};
      OFS_PRIO:  reg_rdata = {{(32-PRIO_W){1'b0}}, prio_q};
      default:   reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/cqt_sva.sv
module cqt_sva #(
  parameter logic [31:0] LEGAL_LO = 32'h0,
  parameter logic [31:0] LEGAL_HI = 32'h8000_0000
) (
  input logic        clk,
  input logic        rst_ni,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        susp_q,
  input logic        rst_go,
  input logic        en_q,
  input logic [31:0] pc_q,
  input logic [31:0] end_q,
  input logic        done_sts
);
  a_r3_fetch_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r9_legal_fetch: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |-> (mem_addr >= LEGAL_LO) && (mem_addr < LEGAL_HI));

  a_r2_warm_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_go |=> !en_q && (pc_q == 32'd0) && (end_q == 32'd0));

  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done_sts) |-> $past(pc_q == end_q));

  a_r7_pause_no_fetch: assert property (@(posedge clk) disable iff (!rst_ni)
    susp_q && !mem_req |=> !mem_req);
endmodule

bind cq_thread_seq cqt_sva #(.LEGAL_LO(LEGAL_LO), .LEGAL_HI(LEGAL_HI)) u_sva (
  .clk(clk), .rst_ni(rst_ni), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .susp_q(susp_q), .rst_go(rst_go), .en_q(en_q),
  .pc_q(pc_q), .end_q(end_q), .done_sts(irq_sts[0]));

// File: tb/sim_cq_thread_seq.sv
`timescale 1ns/1ps
module sim_cq_thread_seq;
  localparam int          SHIFT = 3;
  localparam int          EVT_N = 4;
  localparam int          RSTC  = 5;
  localparam logic [31:0] LO    = 32'h100;
  localparam logic [31:0] HI    = 32'h300;
  localparam logic [31:0] WBASE = LO >> SHIFT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic mem_req, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = 64'h0;
  logic [EVT_N-1:0] evt_in = '0;

  always #10 clk = ~clk;

  cq_thread_seq #(.SHIFT(SHIFT), .EVT_N(EVT_N), .PRIO_W(3), .RST_CYCLES(RSTC),
                  .LEGAL_LO(LO), .LEGAL_HI(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .evt_in(evt_in), .irq(irq));

  int n_chk = 0, n_fail = 0;
  logic [63:0] mem [0:63];
  logic [31:0] obs [0:127];
  logic [31:0] expv [0:127];
  int obs_n = 0, exp_n = 0, lat_fix = -1, lat_cnt = 0;

  // memory responder
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat_cnt = (lat_fix >= 0) ? lat_fix : int'($urandom % 4);
    end else if (mem_req) begin
      if (lat_cnt == 0) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[6'((mem_addr - LO) >> 3)];
        if (obs_n < 128) obs[obs_n] = mem_addr;
        obs_n++;
      end else lat_cnt--;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic thread_reset();
    wr(8'h00, 32'h1);
    idle(RSTC + 2);
    wr(8'h10, 32'h0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 64'h0;
  endtask

  function automatic logic [63:0] nop_w();
    return {8'h00, 24'($urandom), $urandom};
  endfunction

  // reference: expected fetch addresses from start word p to end word e
  function automatic void ref_run(input logic [31:0] p, input logic [31:0] e);
    logic [63:0] ins;
    exp_n = 0;
    while (p != e && exp_n < 128) begin
      expv[exp_n] = p << SHIFT;
      exp_n++;
      ins = mem[6'(p - WBASE)];
      if (ins[63:32] == 32'h1000_0001) p = ins[31:0] >> SHIFT;
      else if (ins[63:32] == 32'h1000_0000) p = p + $unsigned($signed(ins[31:0]) >>> SHIFT);
      else p = p + 1;
    end
  endfunction

  task automatic wait_irq(input int lim);
    int k = 0;
    while (!irq && k < lim) begin @(negedge clk); k++; end
  endtask

  task automatic run_and_check(input logic [31:0] p0, input logic [31:0] e, input string tag);
    obs_n = 0;
    ref_run(p0, e);
    wr(8'h20, p0); wr(8'h24, e); wr(8'h14, 32'h13); wr(8'h04, 32'h1);
    wait_irq(2000);
    idle(4);
    chk(obs_n == exp_n, {tag, " fetch count"}, obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++)
      chk(obs[i] == expv[i], {tag, " fetch address"}, obs[i], expv[i]);
    rd_chk(8'h20, e, {tag, " final pc"});
    rd_chk(8'h10, 32'h1, {tag, " done status"});
  endtask

  initial begin
    logic [31:0] v, x, p0, len;
    int on;
    void'($urandom(32'd4242));
    clear_mem();
    idle(3); rst_n = 1'b1; idle(4);

    // R1: reset values
    rd_chk(8'h04, 32'h0, "R1 enable");
    rd_chk(8'h20, 32'h0, "R1 pc");
    rd_chk(8'h10, 32'h0, "R1 irq status");
    rd_chk(8'h0C, 32'h2, "R1 R7 status when disabled");
    chk(irq == 1'b0, "R1 irq output", irq, 0);

    // R11: priority
    wr(8'h40, 32'h5); rd_chk(8'h40, 32'h5, "R11 priority");

    // R2: warm reset
    wr(8'h20, 32'h33); wr(8'h24, 32'h40);
    wr(8'h00, 32'h1);
    rd_chk(8'h00, 32'h1, "R2 busy bit");
    wr(8'h20, 32'h44);
    idle(RSTC + 2);
    rd_chk(8'h00, 32'h0, "R2 bit self clears");
    rd_chk(8'h20, 32'h0, "R2 pc cleared, write during reset ignored");
    rd_chk(8'h24, 32'h0, "R2 end cleared");
    rd_chk(8'h40, 32'h0, "R2 priority cleared");

    // R3 R4 R5: random programs
    for (int it = 0; it < 8; it++) begin
      thread_reset(); clear_mem();
      p0  = WBASE + ($urandom % 16);
      len = 4 + ($urandom % 13);
      for (int i = 0; i < int'(len); i++) begin
        int r = $urandom % 4;
        int room = int'(len) - i;
        if (r == 2 && room >= 2) begin
          int k = 1 + ($urandom % 2);
          mem[6'(p0 + i - WBASE)] = {32'h1000_0000, 32'(k * 8)};
        end else if (r == 3) begin
          int t = i + 1 + ($urandom % room);
          mem[6'(p0 + i - WBASE)] = {32'h1000_0001, (p0 + 32'(t)) << SHIFT};
        end else mem[6'(p0 + i - WBASE)] = nop_w();
      end
      run_and_check(p0, p0 + len, "R3 R5 random program");
    end

    // R5: backward relative jump
    thread_reset(); clear_mem();
    p0 = WBASE + 8;
    mem[6'(p0 - WBASE)]     = {32'h1000_0000, 32'd24};
    mem[6'(p0 + 3 - WBASE)] = {32'h1000_0000, -32'sd16};
    mem[6'(p0 + 1 - WBASE)] = {32'h1000_0001, (p0 + 32'd4) << SHIFT};
    run_and_check(p0, p0 + 4, "R5 signed relative jump");

    // R10: interrupt status semantics (done bit is set here)
    wr(8'h14, 32'h0);
    idle(1); chk(irq == 1'b0, "R10 irq masked", irq, 0);
    wr(8'h14, 32'h13);
    idle(1); chk(irq == 1'b1, "R10 irq enabled", irq, 1);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h1, "R10 writing one keeps status");
    wr(8'h10, 32'hFFFF_FFFE);
    rd_chk(8'h10, 32'h0, "R10 writing zero clears status");
    idle(1); chk(irq == 1'b0, "R10 irq after clear", irq, 0);

    // R4: thread stays enabled, extending end continues
    rd_chk(8'h04, 32'h1, "R4 still enabled after done");
    on = obs_n; idle(10);
    chk(obs_n == on, "R4 no fetch after done", obs_n, on);
    mem[6'(p0 + 4 - WBASE)] = nop_w();
    wr(8'h24, p0 + 5);
    wait_irq(200); idle(2);
    rd_chk(8'h20, p0 + 5, "R4 continue after end moved");
    chk(obs_n == on + 1, "R4 one extra fetch", obs_n, on + 1);

    // R6: wait on event
    thread_reset(); clear_mem();
    p0 = WBASE + 2;
    mem[6'(p0 - WBASE)] = {32'h2000_0000, 32'd2};
    wr(8'h20, p0); wr(8'h24, p0 + 2); wr(8'h14, 32'h13); wr(8'h04, 32'h1);
    idle(10);
    rd_chk(8'h30, 32'h8000_0000, "R6 wait flag set");
    rd_chk(8'h20, p0, "R6 pc held during wait");
    chk(irq == 1'b0, "R6 no done while waiting", irq, 0);
    evt_in = 4'b0100;
    wait_irq(200); idle(2);
    rd_chk(8'h20, p0 + 2, "R6 resumed after event");
    rd_chk(8'h30, 32'h0, "R6 wait flag cleared");
    evt_in = '0;

    // R6: bad event number
    thread_reset(); clear_mem();
    mem[6'(p0 - WBASE)] = {32'h2000_0000, 32'(EVT_N)};
    wr(8'h20, p0); wr(8'h24, p0 + 2); wr(8'h14, 32'h13); wr(8'h04, 32'h1);
    idle(12);
    rd_chk(8'h10, 32'h10, "R6 bad event error bit 4");
    rd_chk(8'h20, p0, "R6 pc stays on bad wait");

    // R7: pause
    thread_reset(); clear_mem();
    p0 = WBASE;
    wr(8'h08, 32'h1); wr(8'h20, p0); wr(8'h24, p0 + 40); wr(8'h14, 32'h13);
    obs_n = 0;
    wr(8'h04, 32'h1);
    idle(10);
    chk(obs_n == 0, "R7 no fetch while paused", obs_n, 0);
    rd_chk(8'h0C, 32'h2, "R7 stopped flag");
    wr(8'h08, 32'h0);
    idle(8);
    wr(8'h08, 32'h1);
    v = 0;
    for (int k = 0; k < 20 && v != 32'h2; k++) rd(8'h0C, v);
    chk(v == 32'h2, "R7 stopped after pause", v, 2);
    rd(8'h20, x); on = obs_n;
    idle(10);
    rd_chk(8'h20, x, "R7 pc frozen while paused");
    chk(obs_n == on, "R7 fetch count frozen", obs_n, on);
    wr(8'h08, 32'h0);
    wait_irq(500); idle(2);
    rd_chk(8'h20, p0 + 40, "R7 resumed to end");

    // R8: pc write flushes in-flight fetch
    thread_reset(); clear_mem();
    lat_fix = 8; lat_cnt = 8;
    p0 = WBASE;
    mem[6'(p0 - WBASE)] = {32'h1000_0001, (WBASE + 32'd50) << SHIFT};
    wr(8'h20, p0); wr(8'h24, WBASE + 33); wr(8'h14, 32'h13);
    obs_n = 0;
    wr(8'h04, 32'h1);
    idle(2);
    wr(8'h20, WBASE + 32);
    wait_irq(300); idle(2);
    rd_chk(8'h20, WBASE + 33, "R8 ran from written pc");
    rd_chk(8'h10, 32'h1, "R8 flushed instruction not executed");
    chk(obs_n == 2, "R8 fetch count", obs_n, 2);
    chk(obs[1] == (WBASE + 32) << SHIFT, "R8 refetch address", obs[1], (WBASE + 32) << SHIFT);
    lat_fix = -1;

    // R9: illegal fetch address
    thread_reset(); clear_mem();
    obs_n = 0;
    wr(8'h20, 32'h10); wr(8'h24, 32'h30); wr(8'h14, 32'h13); wr(8'h04, 32'h1);
    idle(10);
    chk(obs_n == 0, "R9 no fetch issued", obs_n, 0);
    rd_chk(8'h10, 32'h2, "R9 address error bit 1");
    chk(irq == 1'b1, "R9 R10 irq on error", irq, 1);
    rd_chk(8'h20, 32'h10, "R9 thread stopped");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule